// File: doc/BRIEF.md
# Accessory Insertion and Type Detector

This block watches three pulled-up lines from the bottom connector and the headset jack: an accessory identification line, a shared head-interrupt/data line, and a jack detect line. An accessory pulls the identification line low when it is inserted. The block then raises an interrupt and opens a classification window. The window is timed with a 1 ms tick that the system supplies.

An advanced accessory answers during that window with a low-to-high return on the shared data line. If no such return arrives before the window closes, the accessory is a basic headset. The decision is held until removal. Removal raises the interrupt again and clears the type.

The jack detect line is held high by a normally closed switch while the jack is empty, and a plugged device pulls it low. The block reports this as a plain presence flag. Every line is asynchronous, so each one passes through a two-stage synchronizer and a glitch filter before any edge is taken from it.

Top module: `acc_detect_top`

## Requirements
- R1: A level on any of the three lines that lasts fewer than FILT_LEN clock cycles has no effect on irq, acc_type, acc_present or jack_present.
- R2: A filtered falling edge on id_line_a (insertion) sets irq and acc_present to 1 with acc_type 0 (undecided), FILT_LEN+3 clock cycles after the line changes and not one cycle earlier.
- R3: A filtered rising edge on id_line_a (removal) sets irq to 1 and sets both acc_present and acc_type to 0, in any state.
- R4: A filtered low-to-high edge on hint_line_a while the window is open sets acc_type to 2 (advanced accessory).
- R5: If there is no such edge, acc_type becomes 1 (basic headset) on the WIN_MS-th ms_tick pulse after insertion, and stays 0 after WIN_MS-1 pulses.
- R6: Once acc_type is 1 or 2, later edges on hint_line_a and further ticks leave it unchanged until removal.
- R7: irq stays at 1 until a cycle with irq_ack high clears it. An insertion or removal event in the same cycle as irq_ack wins, and irq stays 1.
- R8: jack_present is 1 while the filtered jack_det_a line is low and 0 while it is high. Jack changes never set irq.
- R9: While rst_n is low and after its release, irq, acc_type, acc_present and jack_present are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond, synchronous to clk |
| id_line_a | input | 1 | Asynchronous accessory identification line, low when an accessory is inserted |
| hint_line_a | input | 1 | Asynchronous shared head-interrupt/data line |
| jack_det_a | input | 1 | Asynchronous headset jack detect line, low when a plug is present |
| irq_ack | input | 1 | Interrupt acknowledge, clears irq |
| irq | output | 1 | Sticky insertion/removal interrupt |
| acc_type | output | 2 | 0 none or undecided, 1 basic headset, 2 advanced accessory |
| acc_present | output | 1 | Accessory inserted |
| jack_present | output | 1 | Plug present in headset jack |

## Verification
A line change driven between clock edges reaches the synchronizer on the next edge. The filter commits it FILT_LEN+2 edges later. The irq/presence/type registers follow one edge after that, so insertion and removal results are due FILT_LEN+3 cycles after the stimulus and a hint edge decides the type on that same count. A tick decides the type on the edge that samples it, and an acknowledge clears irq on the edge that samples it. The directed checks sample one cycle before and exactly at the insertion deadline, and they line an acknowledge up with the event edge. The vector table waits past the deadline, then issues its ticks one by one, so that each row sees a settled result.

// File: rtl/acc_pkg.sv
// Shared types for the accessory detector: type codes, line indices and
// classifier states. Assumes three input lines, all idle-high.
package acc_pkg;
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_BASIC = 2'd1,
        ACC_ADV   = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_WINDOW  = 2'd1,
        ST_SETTLED = 2'd2
    } cls_state_e;

    localparam int LINE_ID   = 0;
    localparam int LINE_HINT = 1;
    localparam int LINE_JACK = 2;
    localparam int NUM_LINES = 3;
endpackage

// File: rtl/acc_line_filter.sv
// Two-flop synchronizer plus glitch filter for one asynchronous line.
// The filtered level moves only after the synchronized input has differed
// from it for FILT_LEN consecutive cycles. One-cycle rise/fall pulses are
// registered together with the level update. Assumes FILT_LEN >= 2.
module acc_line_filter #(
    parameter int   FILT_LEN = 4,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_a,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LIM = CW'(FILT_LEN - 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    // Bring the line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= IDLE_LVL;
            s2 <= IDLE_LVL;
        end else begin
            s1 <= line_a;
            s2 <= s1;
        end
    end

    // Accept a new level only after it has been stable long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= IDLE_LVL;
            cnt   <= '0;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (s2 != level) begin
                if (cnt == LIM) begin
                    level <= s2;
                    cnt   <= '0;
                    rise  <= s2;
                    fall  <= ~s2;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/acc_classifier.sv
// Insertion/removal state and accessory type decision. Insertion opens a
// window of WIN_MS ticks. A rising edge on the shared line inside it marks an
// advanced accessory, and the window expiring marks a basic headset. Removal
// has priority over every other event. Assumes event inputs are one-cycle pulses.
module acc_classifier
    import acc_pkg::*;
#(
    parameter int WIN_MS = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ms_tick,
    input  logic      ins_ev,
    input  logic      rem_ev,
    input  logic      adv_ev,
    output acc_kind_e kind,
    output logic      present
);
    localparam int TW = (WIN_MS > 2) ? $clog2(WIN_MS) : 1;
    localparam logic [TW-1:0] LAST = TW'(WIN_MS - 1);

    cls_state_e    st;
    logic [TW-1:0] ms_cnt;

    // Track attachment and decide the type within the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_EMPTY;
            kind   <= ACC_NONE;
            ms_cnt <= '0;
        end else if (rem_ev) begin
            st     <= ST_EMPTY;
            kind   <= ACC_NONE;
            ms_cnt <= '0;
        end else if (ins_ev) begin
            st     <= ST_WINDOW;
            kind   <= ACC_NONE;
            ms_cnt <= '0;
        end else if (st == ST_WINDOW) begin
            if (adv_ev) begin
                kind <= ACC_ADV;
                st   <= ST_SETTLED;
            end else if (ms_tick) begin
                if (ms_cnt == LAST) begin
                    kind <= ACC_BASIC;
                    st   <= ST_SETTLED;
                end else begin
                    ms_cnt <= ms_cnt + 1'b1;
                end
            end
        end
    end

    // Anything other than empty means an accessory is attached
    always_comb present = (st != ST_EMPTY);
endmodule

// File: rtl/acc_irq_ctl.sv
// Sticky interrupt flag: set by any attach/detach event, cleared by an
// acknowledge. A set in the same cycle as an acknowledge wins.
module acc_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic ack,
    output logic irq
);
    // Hold the request until software acknowledges it
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (set_ev) irq <= 1'b1;
        else if (ack)    irq <= 1'b0;
    end
endmodule

// File: rtl/acc_detect_top.sv
// Accessory insertion and type detector. Filters the identification,
// shared data and jack lines, raises a sticky interrupt on insertion and
// removal, and classifies the accessory in a tick-timed window.
// Assumes ms_tick and irq_ack are synchronous to clk.
module acc_detect_top
    import acc_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int WIN_MS   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       id_line_a,
    input  logic       hint_line_a,
    input  logic       jack_det_a,
    input  logic       irq_ack,
    output logic       irq,
    output logic [1:0] acc_type,
    output logic       acc_present,
    output logic       jack_present
);
    logic [NUM_LINES-1:0] raw, lvl, rise, fall;
    acc_kind_e            kind;

    assign raw[LINE_ID]   = id_line_a;
    assign raw[LINE_HINT] = hint_line_a;
    assign raw[LINE_JACK] = jack_det_a;

    // One conditioner per line, all idle-high
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        acc_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_a (raw[i]),
            .level  (lvl[i]),
            .rise   (rise[i]),
            .fall   (fall[i])
        );
    end

    acc_classifier #(.WIN_MS(WIN_MS)) u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .ins_ev  (fall[LINE_ID]),
        .rem_ev  (rise[LINE_ID]),
        .adv_ev  (rise[LINE_HINT]),
        .kind    (kind),
        .present (acc_present)
    );

    acc_irq_ctl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (fall[LINE_ID] | rise[LINE_ID]),
        .ack    (irq_ack),
        .irq    (irq)
    );

    assign acc_type     = kind;
    assign jack_present = ~lvl[LINE_JACK];

    logic unused_edges;
    assign unused_edges = ^{fall[LINE_HINT], rise[LINE_JACK], fall[LINE_JACK],
                            lvl[LINE_ID], lvl[LINE_HINT]};
endmodule

// File: rtl/acc_detect_chk.sv
// Port-level properties of the accessory detector, bound to the top.
// The window length is checked with a local tick counter.
module acc_detect_chk #(
    parameter int WIN_MS = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ms_tick,
    input logic       irq_ack,
    input logic       irq,
    input logic [1:0] acc_type,
    input logic       acc_present
);
    int win_ticks;

    // Count ticks seen while attached and still undecided
    always_ff @(posedge clk) begin
        if (!rst_n || !acc_present || acc_type != 2'd0) win_ticks <= 0;
        else if (ms_tick)                               win_ticks <= win_ticks + 1;
    end

    // R2
    insert_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_present) |-> (irq && acc_type == 2'd0));

    // R3
    remove_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_present) |-> (irq && acc_type == 2'd0));

    // R4
    type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type != 2'd3) && (acc_type == 2'd0 || acc_present));

    // R5
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ticks <= WIN_MS);

    // R6
    type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type != 2'd0) |=> (!acc_present || acc_type == $past(acc_type)));

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_ack));
endmodule

bind acc_detect_top acc_detect_chk #(.WIN_MS(WIN_MS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .irq_ack     (irq_ack),
    .irq         (irq),
    .acc_type    (acc_type),
    .acc_present (acc_present)
);

// File: tb/tb_acc_detect_top.sv
module tb_acc_detect_top;
    localparam int FILT_LEN = 4;
    localparam int WIN_MS   = 20;
    localparam int LAT      = FILT_LEN + 3;
    localparam int NV       = 13;

    // {ack, id, hint, jack, ticks[4:0], exp irq, exp type[1:0], exp pres, exp jack}
    localparam logic [13:0] VEC [0:NV-1] = '{
        {1'b0,1'b1,1'b1,1'b1,5'd0 ,1'b0,2'd0,1'b0,1'b0}, // idle
        {1'b0,1'b0,1'b0,1'b1,5'd0 ,1'b1,2'd0,1'b1,1'b0}, // R2 insert
        {1'b0,1'b0,1'b0,1'b1,5'd19,1'b1,2'd0,1'b1,1'b0}, // R5 one short
        {1'b0,1'b0,1'b0,1'b1,5'd1 ,1'b1,2'd1,1'b1,1'b0}, // R5 basic
        {1'b1,1'b0,1'b0,1'b1,5'd0 ,1'b0,2'd1,1'b1,1'b0}, // R7 ack
        {1'b0,1'b0,1'b1,1'b1,5'd0 ,1'b0,2'd1,1'b1,1'b0}, // R6 late rise
        {1'b0,1'b1,1'b1,1'b1,5'd0 ,1'b1,2'd0,1'b0,1'b0}, // R3 remove
        {1'b1,1'b1,1'b1,1'b1,5'd0 ,1'b0,2'd0,1'b0,1'b0}, // R7 ack
        {1'b0,1'b0,1'b0,1'b1,5'd5 ,1'b1,2'd0,1'b1,1'b0}, // R2 insert
        {1'b0,1'b0,1'b1,1'b1,5'd0 ,1'b1,2'd2,1'b1,1'b0}, // R4 advanced
        {1'b1,1'b0,1'b1,1'b0,5'd0 ,1'b0,2'd2,1'b1,1'b1}, // R8 jack in
        {1'b0,1'b1,1'b1,1'b0,5'd0 ,1'b1,2'd0,1'b0,1'b1}, // R3 remove
        {1'b1,1'b1,1'b1,1'b1,5'd0 ,1'b0,2'd0,1'b0,1'b0}  // R8 jack out
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       id_line_a = 1'b1;
    logic       hint_line_a = 1'b1;
    logic       jack_det_a = 1'b1;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic [1:0] acc_type;
    logic       acc_present;
    logic       jack_present;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    acc_detect_top #(.FILT_LEN(FILT_LEN), .WIN_MS(WIN_MS)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .id_line_a    (id_line_a),
        .hint_line_a  (hint_line_a),
        .jack_det_a   (jack_det_a),
        .irq_ack      (irq_ack),
        .irq          (irq),
        .acc_type     (acc_type),
        .acc_present  (acc_present),
        .jack_present (jack_present)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state
        wait_neg(3);
        chk("R9 irq in reset", irq, 0);
        chk("R9 type in reset", acc_type, 0);
        rst_n = 1'b1;
        wait_neg(2);
        chk("R9 present after reset", acc_present, 0);
        chk("R9 jack after reset", jack_present, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            irq_ack     = VEC[v][13];
            id_line_a   = VEC[v][12];
            hint_line_a = VEC[v][11];
            jack_det_a  = VEC[v][10];
            @(negedge clk);
            irq_ack = 1'b0;
            wait_neg(LAT + 1);
            tick(int'(VEC[v][9:5]));
            chk($sformatf("row%0d R2/R3/R7 irq", v), irq, int'(VEC[v][4]));
            chk($sformatf("row%0d R4/R5/R6 type", v), acc_type, int'(VEC[v][3:2]));
            chk($sformatf("row%0d R2/R3 present", v), acc_present, int'(VEC[v][1]));
            chk($sformatf("row%0d R8 jack", v), jack_present, int'(VEC[v][0]));
        end

        // R2 exact insertion latency
        id_line_a   = 1'b0;
        hint_line_a = 1'b0;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 irq one cycle early", irq, 0);
        @(negedge clk);
        chk("R2 irq on time", irq, 1);
        chk("R2 present on time", acc_present, 1);

        // R7 event and acknowledge in the same cycle
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R7 ack clears", irq, 0);
        id_line_a = 1'b1;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R7 set beats ack", irq, 1);
        chk("R3 removed", acc_present, 0);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        hint_line_a = 1'b1;
        wait_neg(LAT + 2);

        // R1 short pulses are dropped
        id_line_a  = 1'b0;
        jack_det_a = 1'b0;
        wait_neg(FILT_LEN - 1);
        id_line_a  = 1'b1;
        jack_det_a = 1'b1;
        wait_neg(LAT + 4);
        chk("R1 glitch irq", irq, 0);
        chk("R1 glitch present", acc_present, 0);
        chk("R1 glitch jack", jack_present, 0);

        // R8 jack change does not interrupt
        jack_det_a = 1'b0;
        wait_neg(LAT + 2);
        chk("R8 jack present", jack_present, 1);
        chk("R8 jack no irq", irq, 0);
        jack_det_a = 1'b1;
        wait_neg(LAT + 2);
        chk("R8 jack gone", jack_present, 0);

        // R9 reset during attachment
        id_line_a = 1'b0;
        wait_neg(LAT + 2);
        chk("R2 attached before reset", acc_present, 1);
        rst_n = 1'b0;
        id_line_a = 1'b1;
        wait_neg(2);
        chk("R9 irq cleared", irq, 0);
        chk("R9 present cleared", acc_present, 0);
        rst_n = 1'b1;
        wait_neg(LAT + 2);
        chk("R9 stays clear", irq, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule